// File: doc/BRIEF.md
# Load/Store Address and Address-Space Unit

This unit sits between the integer pipeline and a simple request/response memory bus. For each memory operation it is handed, it adds the two register operands, or the first operand and a sign-extended 13-bit immediate, to form a byte address. It picks the 8-bit address-space identifier from the privilege level and the access kind, or takes it from the instruction for an alternate-space access. It then places the store data and byte enables on a 64-bit big-endian data path. Load data that comes back is extracted and sign- or zero-extended.

Operations that the unit cannot legally start are rejected in the cycle after they are offered. An alternate-space access in immediate form, an alternate-space access from user mode and a misaligned address each raise their own trap output, and none of them reaches the bus. Two atomic operations hold the bus lock across a read followed by a write. One returns the old byte and leaves that byte all ones. The other exchanges a register word with a memory word.

Top module: `lsu_asi_unit`

## Requirements
- R1: The address on `bus_addr` is `op_rs1 + op_rs2` when `op_imm`=0, and `op_rs1` plus `op_simm` sign-extended to 32 bits when `op_imm`=1, with full byte granularity and 32-bit wraparound.
- R2: Ordinary accesses drive `bus_asi` 0x0A for user data, 0x0B for supervisor data, 0x08 for a user fetch and 0x09 for a supervisor fetch. `op_super`=1 means supervisor. A fetch (`op_fetch`=1) is always a word read and ignores `op_load`, `op_atom`, `op_size`, `op_signed` and `op_alt`.
- R3: In supervisor mode with `op_imm`=0, an alternate-space access (`op_alt`=1) drives `bus_asi` equal to `op_asi`.
- R4: An alternate-space access with `op_imm`=1 raises `trap_illegal` together with `done` in the cycle after acceptance, with no bus request, whatever the privilege.
- R5: An alternate-space access in user mode with `op_imm`=0 raises `trap_priv` together with `done` in the cycle after acceptance, with no bus request.
- R6: When no other trap applies, an address that is not a multiple of the access size raises `trap_align` with `done` and issues no request. Size codes: 0 byte, 1 halfword, 2 word, 3 doubleword. At most one trap output is high at a time.
- R7: Byte offset k = address[2:0] maps to lane bits [63-8k:56-8k] and to `bus_be` bit 7-k (big-endian). Store data comes from the low bytes of `op_stdata`, with its most significant byte at the lowest address. Unused lanes drive zero.
- R8: When the access completes, `ld_data` holds byte and halfword loads sign-extended if `op_signed`=1 and zero-extended otherwise. Word loads are zero-extended and doubleword loads fill all 64 bits.
- R9: `op_atom`=1 (set-byte) reads one byte under lock, then writes 0xFF to the same byte under lock. `ld_data` returns the old byte zero-extended.
- R10: `op_atom`=2 (exchange) reads a word under lock, then writes `op_stdata[31:0]` to the same word under lock. `ld_data` returns the old word. `bus_lock` stays high from the first request through the final acknowledge.
- R11: The request appears in the cycle after acceptance and holds its address, direction and data until `bus_ack`. `done` rises in the cycle after the final acknowledge.
- R12: `op_ready` is low from acceptance until `done`, and `op_valid` is ignored while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, offer is taken |
| op_fetch | input | 1 | Instruction fetch |
| op_load | input | 1 | 1 load, 0 store (plain accesses) |
| op_atom | input | 2 | 0 none, 1 set-byte, 2 exchange |
| op_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| op_signed | input | 1 | Sign-extend byte/half loads |
| op_alt | input | 1 | Alternate-space access |
| op_asi | input | 8 | Space identifier from the instruction |
| op_imm | input | 1 | Use immediate as second operand |
| op_super | input | 1 | Supervisor mode |
| op_rs1 | input | 32 | First register operand |
| op_rs2 | input | 32 | Second register operand |
| op_simm | input | 13 | Signed immediate |
| op_stdata | input | 64 | Store / exchange data |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Write phase |
| bus_lock | output | 1 | Atomic lock |
| bus_addr | output | 32 | Byte address |
| bus_asi | output | 8 | Address-space identifier |
| bus_be | output | 8 | Byte enables, bit 7 = offset 0 |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_rdata | input | 64 | Read data, valid with ack |
| done | output | 1 | Operation finished (one cycle) |
| ld_data | output | 64 | Extended load result |
| trap_illegal | output | 1 | Illegal-form trap |
| trap_priv | output | 1 | Privilege trap |
| trap_align | output | 1 | Alignment trap |

## Verification
A request is visible one cycle after the edge that accepts the operation. A rejected operation instead shows `done` and its trap output in that same cycle. `done` and `ld_data` follow the edge that consumes the final acknowledge by one register stage, and the write phase of an atomic operation starts at that same edge. The bench drives the acknowledge and samples every output one nanosecond after the falling edge. It stamps each acknowledge with the cycle number of the consuming edge and requires `done` to be first seen in exactly that cycle, or in the acceptance cycle for traps. Random-latency responses (0 to 4 cycles of waiting) make sure the unit holds each request for as long as the bus stalls.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        AT_NONE    = 2'd0,
        AT_SETBYTE = 2'd1,
        AT_XCHG    = 2'd2
    } atom_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SINGLE = 2'd1,
        PH_ARD    = 2'd2,
        PH_AWR    = 2'd3
    } phase_e;

    localparam logic [7:0] SPACE_USR_INS = 8'h08;
    localparam logic [7:0] SPACE_SUP_INS = 8'h09;
    localparam logic [7:0] SPACE_USR_DAT = 8'h0A;
    localparam logic [7:0] SPACE_SUP_DAT = 8'h0B;

endpackage

// File: rtl/lsu_agen.sv
// Address adder, space-identifier select and legality checks.
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIMM_W = 13,
    parameter int ASI_W  = 8
) (
    input  logic [ADDR_W-1:0] rs1,
    input  logic [ADDR_W-1:0] rs2,
    input  logic [SIMM_W-1:0] simm,
    input  logic              use_imm,
    input  logic              fetch,
    input  logic              alt,
    input  logic [ASI_W-1:0]  asi_field,
    input  logic              sup,
    input  size_e             size,
    output logic [ADDR_W-1:0] addr,
    output logic [ASI_W-1:0]  asi,
    output logic              trap_ill,
    output logic              trap_priv,
    output logic              trap_align
);
    localparam int EXT_W = ADDR_W - SIMM_W;

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] size_mask;
    logic              alt_eff;

    assign imm_ext = {{EXT_W{simm[SIMM_W-1]}}, simm};
    assign addr    = rs1 + (use_imm ? imm_ext : rs2);
    assign alt_eff = alt & ~fetch;

    always_comb begin
        size_mask = '0;
        case (size)
            SZ_BYTE:  size_mask[2:0] = 3'b000;
            SZ_HALF:  size_mask[2:0] = 3'b001;
            SZ_WORD:  size_mask[2:0] = 3'b011;
            default:  size_mask[2:0] = 3'b111;
        endcase
    end

    assign trap_ill   = alt_eff & use_imm;
    assign trap_priv  = alt_eff & ~use_imm & ~sup;
    assign trap_align = ~trap_ill & ~trap_priv & (|(addr & size_mask));

    always_comb begin
        if (alt_eff)    asi = asi_field;
        else if (fetch) asi = sup ? ASI_W'(SPACE_SUP_INS) : ASI_W'(SPACE_USR_INS);
        else            asi = sup ? ASI_W'(SPACE_SUP_DAT) : ASI_W'(SPACE_USR_DAT);
    end

endmodule

// File: rtl/lsu_wlane.sv
// Places store data and byte enables on the big-endian lanes.
module lsu_wlane
    import lsu_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int BE_W  = DATA_W / 8,
    localparam int OFF_W = $clog2(BE_W)
) (
    input  logic [OFF_W-1:0]  off,
    input  size_e             size,
    input  logic [DATA_W-1:0] data,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] wdata
);
    localparam logic [DATA_W-1:0] D_ONE = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [BE_W-1:0]   B_ONE = {{(BE_W-1){1'b0}}, 1'b1};

    int                nb;
    int                lo;
    logic [DATA_W-1:0] dmask;
    logic [BE_W-1:0]   bmask;

    always_comb begin
        case (size)
            SZ_BYTE: nb = 1;
            SZ_HALF: nb = 2;
            SZ_WORD: nb = 4;
            default: nb = 8;
        endcase
        lo = BE_W - int'(off) - nb;
        if (lo < 0) lo = 0;
        dmask = (nb >= BE_W) ? '1 : ((D_ONE << (8 * nb)) - D_ONE);
        bmask = (nb >= BE_W) ? '1 : ((B_ONE << nb) - B_ONE);
        be    = bmask << lo;
        wdata = (data & dmask) << (8 * lo);
    end

endmodule

// File: rtl/lsu_rext.sv
// Picks the addressed bytes out of the read lanes and extends them.
module lsu_rext
    import lsu_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int BE_W  = DATA_W / 8,
    localparam int OFF_W = $clog2(BE_W)
) (
    input  logic [OFF_W-1:0]  off,
    input  size_e             size,
    input  logic              sgn,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] raw;
    int                nb;
    int                lo;

    always_comb begin
        case (size)
            SZ_BYTE: nb = 1;
            SZ_HALF: nb = 2;
            SZ_WORD: nb = 4;
            default: nb = 8;
        endcase
        lo = BE_W - int'(off) - nb;
        if (lo < 0) lo = 0;
        raw = rdata >> (8 * lo);
        case (size)
            SZ_BYTE: value = {{(DATA_W-8){sgn & raw[7]}}, raw[7:0]};
            SZ_HALF: value = {{(DATA_W-16){sgn & raw[15]}}, raw[15:0]};
            SZ_WORD: value = {{(DATA_W-32){1'b0}}, raw[31:0]};
            default: value = raw;
        endcase
    end

endmodule

// File: rtl/lsu_asi_unit.sv
module lsu_asi_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SIMM_W = 13,
    parameter int ASI_W  = 8,
    localparam int BE_W  = DATA_W / 8,
    localparam int OFF_W = $clog2(BE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_fetch,
    input  logic              op_load,
    input  logic [1:0]        op_atom,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic              op_alt,
    input  logic [ASI_W-1:0]  op_asi,
    input  logic              op_imm,
    input  logic              op_super,
    input  logic [ADDR_W-1:0] op_rs1,
    input  logic [ADDR_W-1:0] op_rs2,
    input  logic [SIMM_W-1:0] op_simm,
    input  logic [DATA_W-1:0] op_stdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ASI_W-1:0]  bus_asi,
    output logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] ld_data,
    output logic              trap_illegal,
    output logic              trap_priv,
    output logic              trap_align
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [ASI_W-1:0]  asi;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
        logic              we;
        size_e             size;
        logic              sgn;
        atom_e             atom;
        logic [DATA_W-1:0] res;
        logic              done;
        logic              t_ill;
        logic              t_priv;
        logic              t_align;
    } state_t;

    state_t d, q;

    atom_e             atom_eff;
    size_e             size_eff;
    logic              sgn_eff;
    logic [ADDR_W-1:0] ag_addr;
    logic [ASI_W-1:0]  ag_asi;
    logic              ag_ill, ag_priv, ag_align;
    logic [BE_W-1:0]   wl_be;
    logic [DATA_W-1:0] wl_wdata;
    logic [DATA_W-1:0] wl_src;
    logic [DATA_W-1:0] rx_val;

    // Operation decode: a fetch overrides every other type field.
    always_comb begin
        if (op_fetch || op_atom == 2'd3) atom_eff = AT_NONE;
        else                             atom_eff = atom_e'(op_atom);
        if (op_fetch)                    size_eff = SZ_WORD;
        else if (atom_eff == AT_SETBYTE) size_eff = SZ_BYTE;
        else if (atom_eff == AT_XCHG)    size_eff = SZ_WORD;
        else                             size_eff = size_e'(op_size);
        sgn_eff = op_signed && !op_fetch && (atom_eff == AT_NONE);
        wl_src  = (atom_eff == AT_SETBYTE) ? {{(DATA_W-8){1'b0}}, 8'hFF} : op_stdata;
    end

    lsu_agen #(
        .ADDR_W(ADDR_W), .SIMM_W(SIMM_W), .ASI_W(ASI_W)
    ) u_agen (
        .rs1(op_rs1), .rs2(op_rs2), .simm(op_simm), .use_imm(op_imm),
        .fetch(op_fetch), .alt(op_alt), .asi_field(op_asi), .sup(op_super),
        .size(size_eff), .addr(ag_addr), .asi(ag_asi),
        .trap_ill(ag_ill), .trap_priv(ag_priv), .trap_align(ag_align)
    );

    lsu_wlane #(.DATA_W(DATA_W)) u_wlane (
        .off(ag_addr[OFF_W-1:0]), .size(size_eff), .data(wl_src),
        .be(wl_be), .wdata(wl_wdata)
    );

    lsu_rext #(.DATA_W(DATA_W)) u_rext (
        .off(q.addr[OFF_W-1:0]), .size(q.size), .sgn(q.sgn),
        .rdata(bus_rdata), .value(rx_val)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.t_ill   = 1'b0;
        d.t_priv  = 1'b0;
        d.t_align = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (op_valid) begin
                    d.t_ill   = ag_ill;
                    d.t_priv  = ag_priv;
                    d.t_align = ag_align;
                    if (ag_ill || ag_priv || ag_align) begin
                        d.done = 1'b1;
                    end else begin
                        d.addr  = ag_addr;
                        d.asi   = ag_asi;
                        d.be    = wl_be;
                        d.wdata = wl_wdata;
                        d.size  = size_eff;
                        d.sgn   = sgn_eff;
                        d.atom  = atom_eff;
                        d.we    = (atom_eff == AT_NONE) && !op_fetch && !op_load;
                        d.ph    = (atom_eff == AT_NONE) ? PH_SINGLE : PH_ARD;
                    end
                end
            end
            PH_SINGLE: begin
                if (bus_ack) begin
                    d.ph   = PH_IDLE;
                    d.done = 1'b1;
                    if (!q.we) d.res = rx_val;
                end
            end
            PH_ARD: begin
                if (bus_ack) begin
                    d.ph  = PH_AWR;
                    d.we  = 1'b1;
                    d.res = rx_val;
                end
            end
            default: begin
                if (bus_ack) begin
                    d.ph   = PH_IDLE;
                    d.we   = 1'b0;
                    d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign op_ready     = (q.ph == PH_IDLE);
    assign bus_req      = (q.ph != PH_IDLE);
    assign bus_lock     = (q.ph == PH_ARD) || (q.ph == PH_AWR);
    assign bus_we       = q.we;
    assign bus_addr     = q.addr;
    assign bus_asi      = q.asi;
    assign bus_be       = q.be;
    assign bus_wdata    = q.wdata;
    assign done         = q.done;
    assign ld_data      = q.res;
    assign trap_illegal = q.t_ill;
    assign trap_priv    = q.t_priv;
    assign trap_align   = q.t_align;

    // R11: a stalled request holds its address and direction
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R11: a completion without trap follows an acknowledged request
    assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done && !(trap_illegal || trap_priv || trap_align) |-> $past(bus_req && bus_ack));

    // R10: a locked read is followed at once by a locked write to the same place
    assert_lock_span_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock && bus_req && bus_ack && !bus_we |=> bus_lock && bus_req && bus_we && $stable(bus_addr));

    // R6: a trapped operation never reaches the bus
    assert_trap_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_illegal || trap_priv || trap_align) |-> !bus_req && done);

    // R6: never more than one trap at once
    assert_one_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_illegal, trap_priv, trap_align}));

    // R6: issued addresses are aligned to the enabled lane count
    assert_aligned_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[OFF_W-1:0] & OFF_W'($countones(bus_be) - 1)) == '0);

    // R9: the set-byte write phase drives ones in every enabled lane
    assert_setbyte_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_lock && $countones(bus_be) == 1 |->
        $countones(bus_wdata) == 8);

endmodule

// File: tb/lsu_asi_unit_test.sv
`timescale 1ns/1ps
module lsu_asi_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic        op_fetch = 1'b0, op_load = 1'b0, op_signed = 1'b0, op_alt = 1'b0;
    logic        op_imm = 1'b0, op_super = 1'b0;
    logic [1:0]  op_atom = 2'd0, op_size = 2'd0;
    logic [7:0]  op_asi = 8'd0;
    logic [31:0] op_rs1 = '0, op_rs2 = '0;
    logic [12:0] op_simm = '0;
    logic [63:0] op_stdata = '0;
    logic        bus_req, bus_we, bus_lock;
    logic [31:0] bus_addr;
    logic [7:0]  bus_asi, bus_be;
    logic [63:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_rdata = '0;
    logic        done;
    logic [63:0] ld_data;
    logic        trap_illegal, trap_priv, trap_align;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    lsu_asi_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_fetch(op_fetch), .op_load(op_load), .op_atom(op_atom), .op_size(op_size),
        .op_signed(op_signed), .op_alt(op_alt), .op_asi(op_asi), .op_imm(op_imm),
        .op_super(op_super), .op_rs1(op_rs1), .op_rs2(op_rs2), .op_simm(op_simm),
        .op_stdata(op_stdata), .bus_req(bus_req), .bus_we(bus_we), .bus_lock(bus_lock),
        .bus_addr(bus_addr), .bus_asi(bus_asi), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .ld_data(ld_data),
        .trap_illegal(trap_illegal), .trap_priv(trap_priv), .trap_align(trap_align)
    );

    // ---------------- bus responder ----------------
    int          lat_cfg = 0;
    int          wcnt = 0;
    int          txn_n = 0;
    int          last_ack_cyc = 0;
    logic [31:0] t_addr [4];
    logic [7:0]  t_asi  [4];
    logic [7:0]  t_be   [4];
    logic        t_we   [4];
    logic        t_lock [4];
    logic [63:0] t_wd   [4];

    function automatic logic [63:0] f_pat(input logic [31:0] a);
        logic [63:0] w;
        w = {32'h0, a[31:3], 3'b000};
        return (w * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0F1E_2D3C_4B5A_6978;
    endfunction

    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
            last_ack_cyc = cyc;
            wcnt = 0;
        end else if (bus_req) begin
            if (wcnt >= lat_cfg) begin
                if (txn_n < 4) begin
                    t_addr[txn_n] = bus_addr; t_asi[txn_n] = bus_asi;
                    t_be[txn_n] = bus_be; t_we[txn_n] = bus_we;
                    t_lock[txn_n] = bus_lock; t_wd[txn_n] = bus_wdata;
                end
                txn_n++;
                bus_rdata = f_pat(bus_addr);
                bus_ack = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    // ---------------- expectation helpers ----------------
    function automatic logic [7:0] f_be(input int o, input int nb);
        logic [7:0] b = '0;
        for (int k = 0; k < nb; k++) b[7-(o+k)] = 1'b1;
        return b;
    endfunction

    function automatic logic [63:0] f_place(input logic [63:0] d, input int o, input int nb);
        logic [63:0] w = '0;
        for (int k = 0; k < nb; k++) w[63-8*(o+k) -: 8] = d[8*(nb-1-k) +: 8];
        return w;
    endfunction

    function automatic logic [63:0] f_ext(input logic [63:0] r, input int o, input int nb, input logic s);
        logic [63:0] v = '0;
        for (int k = 0; k < nb; k++) v[8*(nb-1-k) +: 8] = r[63-8*(o+k) -: 8];
        if (s && nb == 1 && v[7])  v[63:8]  = '1;
        if (s && nb == 2 && v[15]) v[63:16] = '1;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- one operation ----------------
    task automatic run_op(input logic f, input logic ld, input logic [1:0] at, input logic [1:0] sz,
                          input logic sg, input logic al, input logic [7:0] asi, input logic im,
                          input logic su, input logic [31:0] r1, input logic [31:0] r2,
                          input logic [12:0] si, input logic [63:0] sd, input int lat,
                          input logic poke);
        int          nb, o, acc_cyc, done_cyc, exp_n;
        logic        alt_e, e_ill, e_priv, e_al, e_we, sg_e;
        logic [31:0] ea;
        logic [7:0]  easi;
        logic [1:0]  es;
        logic        seen;
        es = f ? 2'd2 : (at == 2'd1) ? 2'd0 : (at == 2'd2) ? 2'd2 : sz;
        nb = 1 << es;
        alt_e  = al && !f;
        e_ill  = alt_e && im;
        e_priv = alt_e && !im && !su;
        ea     = r1 + (im ? {{19{si[12]}}, si} : r2);
        e_al   = !e_ill && !e_priv && (ea % nb != 0);
        easi   = alt_e ? asi : f ? (su ? 8'h09 : 8'h08) : (su ? 8'h0B : 8'h0A);
        o      = int'(ea[2:0]);
        e_we   = !f && at == 2'd0 && !ld;
        sg_e   = sg && !f && at == 2'd0;
        exp_n  = (e_ill || e_priv || e_al) ? 0 : (!f && at != 2'd0) ? 2 : 1;

        @(negedge clk);
        lat_cfg = lat; txn_n = 0;
        op_fetch = f; op_load = ld; op_atom = at; op_size = sz; op_signed = sg;
        op_alt = al; op_asi = asi; op_imm = im; op_super = su;
        op_rs1 = r1; op_rs2 = r2; op_simm = si; op_stdata = sd;
        op_valid = 1'b1;
        @(negedge clk); #1;
        op_valid = 1'b0;
        acc_cyc = cyc;
        if (exp_n != 0) chk("R12 ready low while busy", {63'd0, op_ready}, 64'd0);
        seen = 1'b0;
        for (int k = 0; k < 60; k++) begin
            if (done) begin seen = 1'b1; break; end
            if (poke && k == 1) begin op_valid = 1'b1; op_load = 1'b0; end
            @(negedge clk); #1;
            op_valid = 1'b0;
        end
        done_cyc = cyc;
        chk("R11 done seen", {63'd0, seen}, 64'd1);
        chk("R4 illegal flag", {63'd0, trap_illegal}, {63'd0, e_ill});
        chk("R5 priv flag", {63'd0, trap_priv}, {63'd0, e_priv});
        chk("R6 align flag", {63'd0, trap_align}, {63'd0, e_al});
        if (exp_n == 0) begin
            chk("R6 no request on trap", 64'(txn_n), 64'd0);
            chk("R11 trap timing", 64'(done_cyc), 64'(acc_cyc));
        end else begin
            chk("R11 txn count", 64'(txn_n), 64'(exp_n));
            chk("R1 address", {32'd0, t_addr[0]}, {32'd0, ea});
            chk("R2 R3 space id", {56'd0, t_asi[0]}, {56'd0, easi});
            chk("R7 byte enables", {56'd0, t_be[0]}, {56'd0, f_be(o, nb)});
            chk("R11 direction", {63'd0, t_we[0]}, {63'd0, e_we});
            chk("R10 lock first phase", {63'd0, t_lock[0]}, {63'd0, at != 2'd0 && !f});
            chk("R11 done timing", 64'(done_cyc), 64'(last_ack_cyc));
            if (e_we) chk("R7 store lanes", t_wd[0], f_place(sd, o, nb));
            else chk("R8 load result", ld_data, f_ext(f_pat(ea), o, nb, sg_e));
            if (exp_n == 2) begin
                chk("R10 write phase addr", {32'd0, t_addr[1]}, {32'd0, ea});
                chk("R10 write phase dir+lock", {62'd0, t_we[1], t_lock[1]}, 64'd3);
                chk("R9 R10 write lanes", t_wd[1],
                    f_place((at == 2'd1) ? 64'hFF : sd, o, nb));
            end
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            #1;
            chk("R12 offer while busy ignored", 64'(txn_n), 64'(exp_n));
            chk("R12 bus idle afterwards", {63'd0, bus_req}, 64'd0);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] r1, r2;
        logic [12:0] si;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R12 reset ready", {63'd0, op_ready}, 64'd1);
        chk("R11 reset no request", {62'd0, bus_req, bus_lock}, 64'd0);
        chk("R11 reset no done", {63'd0, done}, 64'd0);

        // R1 immediate, negative displacement
        run_op(0, 1, 0, 2, 0, 0, 8'h00, 1, 0, 32'h0000_1000, 32'h0, 13'h1FF8, 64'h0, 0, 0);
        // R1 wraparound with two registers, doubleword
        run_op(0, 1, 0, 3, 0, 0, 8'h00, 0, 1, 32'hFFFF_FFF8, 32'h10, 13'h0, 64'h0, 1, 0);
        // R2 fetch user and supervisor; fetch ignores alt
        run_op(1, 0, 0, 0, 1, 1, 8'h55, 0, 0, 32'h400, 32'h4, 13'h0, 64'h0, 0, 0);
        run_op(1, 0, 0, 0, 0, 0, 8'h00, 1, 1, 32'h800, 32'h0, 13'h0C, 64'h0, 2, 0);
        // R3 alternate space in supervisor mode
        run_op(0, 1, 0, 1, 1, 1, 8'h2F, 0, 1, 32'h2000, 32'h6, 13'h0, 64'h0, 0, 0);
        // R4 alt+imm (user and supervisor), R5 alt user
        run_op(0, 1, 0, 2, 0, 1, 8'h20, 1, 0, 32'h0, 32'h0, 13'h3, 64'h0, 0, 0);
        run_op(0, 1, 0, 2, 0, 1, 8'h20, 1, 1, 32'h0, 32'h0, 13'h4, 64'h0, 0, 0);
        run_op(0, 0, 0, 2, 0, 1, 8'h20, 0, 0, 32'h10, 32'h3, 13'h0, 64'h0, 0, 0);
        // R6 misaligned halfword and doubleword
        run_op(0, 1, 0, 1, 0, 0, 8'h00, 0, 0, 32'h101, 32'h0, 13'h0, 64'h0, 0, 0);
        run_op(0, 0, 0, 3, 0, 0, 8'h00, 1, 1, 32'h100, 32'h0, 13'h4, 64'h0, 0, 0);
        // R7 byte stores at offsets 0 and 7, halfword at 6
        run_op(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 32'h200, 32'h0, 13'h0, 64'h1122_3344_5566_77A5, 0, 0);
        run_op(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 32'h207, 32'h0, 13'h0, 64'h1122_3344_5566_77A5, 0, 0);
        run_op(0, 0, 0, 1, 0, 0, 8'h00, 0, 1, 32'h206, 32'h0, 13'h0, 64'h0000_0000_0000_BEEF, 1, 0);
        // R8 signed byte/half loads at every byte offset
        for (int k = 0; k < 8; k++)
            run_op(0, 1, 0, 0, 1, 0, 8'h00, 0, 0, 32'h3000 + k, 32'h0, 13'h0, 64'h0, 0, 0);
        run_op(0, 1, 0, 1, 1, 0, 8'h00, 0, 0, 32'h3A02, 32'h0, 13'h0, 64'h0, 0, 0);
        // R9 set-byte, R10 exchange (plus alternate-space exchange)
        run_op(0, 1, 1, 3, 1, 0, 8'h00, 0, 1, 32'h500, 32'h5, 13'h0, 64'h0, 2, 0);
        run_op(0, 0, 2, 0, 0, 0, 8'h00, 1, 0, 32'h600, 32'h0, 13'h4, 64'hDEAD_BEEF_CAFE_F00D, 1, 0);
        run_op(0, 0, 2, 0, 0, 1, 8'h41, 0, 1, 32'h700, 32'h8, 13'h0, 64'h0123_4567_89AB_CDEF, 0, 0);
        run_op(0, 0, 2, 0, 0, 0, 8'h00, 0, 0, 32'h701, 32'h0, 13'h0, 64'h0, 0, 0);
        // R11 long stall, R12 offer during busy
        run_op(0, 1, 0, 2, 0, 0, 8'h00, 0, 0, 32'h900, 32'h4, 13'h0, 64'h0, 4, 1);

        // constrained random
        for (int n = 0; n < 250; n++) begin
            r1 = $urandom;
            r2 = $urandom;
            si = 13'($urandom);
            if ($urandom % 4 != 0) begin r1[2:0] = '0; r2[2:0] = '0; si[2:0] = '0; end
            run_op(($urandom % 8) == 0, 1'($urandom), 2'($urandom % 3), 2'($urandom),
                   1'($urandom), ($urandom % 4) == 0, 8'($urandom), 1'($urandom),
                   1'($urandom), r1, r2, si, {$urandom, $urandom}, int'($urandom % 5), 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule